// File: doc/BRIEF.md
# Threshold Interrupt Status Unit

This block collects FIFO condition events for a serial flash engine and turns them into one level-sensitive interrupt. It compares the current transmit and receive FIFO occupancy counts against two programmable threshold registers and against the FIFO's empty and full levels. Each condition sets a sticky bit in a status register. Software clears a status bit by writing a one to it. When the condition that set the bit is still present, the bit comes back one cycle later.

The interrupt mask cannot be written directly. Writing a one to the set address turns a mask bit on. Writing a one to the clear address turns it off. Zeros written to either address change nothing. The current mask is read back at its own address. The interrupt output is high while any status bit is set and its mask bit is also set.

All registers sit on a simple 32-bit write/read bus with byte addresses. Reads are combinational from the address. Writes take effect on the clock edge where the write strobe is high. Bits 0 and 6 of the status word are kept for future fault sources and always read zero.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is held, the status word (0x04) reads 0, the mask (0x10) reads 0, the transmit threshold (0x28) reads TX_THR_INIT (default 1), the receive threshold (0x2C) reads RX_THR_INIT (default 32), and irq is low.
- R2: Status bit 2 becomes set on the clock edge after any cycle in which txLevel is strictly less than the transmit threshold.
- R3: Status bit 4 becomes set on the clock edge after any cycle in which rxLevel is nonzero.
- R4: Status bit 1 sets when rxLevel is at or above the receive threshold. Bit 3 sets when txLevel equals FIFO_DEPTH (default 63). Bit 5 sets when rxLevel equals FIFO_DEPTH. Bits 0, 6 and 31:7 of the status word always read 0.
- R5: A status bit stays set after its condition goes away, until software clears it.
- R6: Writing to 0x04 clears every status bit whose data bit is 1 and leaves bits written with 0 unchanged. A cleared bit whose condition still holds reads 0 right after the write and reads 1 one clock later.
- R7: Writing to 0x08 sets each mask bit whose data bit is 1. Bits written with 0 are unchanged, and data bits above 6 are ignored. The mask reads back on bits 6:0 of 0x10.
- R8: Writing to 0x0C clears each mask bit whose data bit is 1. Bits written with 0 are unchanged.
- R9: irq is high exactly when some bit is set in both the status word and the mask. It follows a status or mask update without any further clock.
- R10: The thresholds at 0x28 and 0x2C are read/write. Only the low LVL_W bits (default 6) of the written data are stored, and the upper bits read 0.
- R11: Reads of 0x08, 0x0C and any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (8) | Byte address for reads and writes |
| busWe | input | 1 | Write strobe, active for one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| txLevel | input | LVL_W (6) | Transmit FIFO occupancy count |
| rxLevel | input | LVL_W (6) | Receive FIFO occupancy count |
| irq | output | 1 | Level interrupt request |

## Verification
A table of occupancy and threshold combinations covers several cases. The transmit level is placed just below, exactly at, and above its threshold, which tells a strict less-than apart from less-or-equal. The receive level is placed at its threshold and one below it, which tells greater-or-equal apart from strictly greater. Both levels are also driven to empty and to full, and the thresholds are set to zero. Each row uses its own mask, so each row also checks irq gating. Directed sequences check three more things. A bit set by a short condition pulse is kept after the pulse. A one-hot clear leaves its neighbours alone. A bit cleared while its condition persists reads back 0 for exactly one cycle.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  // Number of status/mask bits carried by the unit.
  localparam int IRQ_W = 7;

  // Byte offsets of the register set; software decodes these.
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_MSET  = 'h08;
  localparam int OFF_MCLR  = 'h0C;
  localparam int OFF_MASK  = 'h10;
  localparam int OFF_TXTHR = 'h28;
  localparam int OFF_RXTHR = 'h2C;

  // Status bit positions.
  localparam int B_RX_AT_THR = 1;
  localparam int B_TX_BELOW  = 2;
  localparam int B_TX_FULL   = 3;
  localparam int B_RX_AVAIL  = 4;
  localparam int B_RX_FULL   = 5;

  // Write strobes from decode to datapath.
  typedef struct packed {
    logic statClr;
    logic maskSet;
    logic maskClr;
    logic txThrWr;
    logic rxThrWr;
  } strobe_t;

  // Read source selection.
  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT,
    RD_MASK,
    RD_TXTHR,
    RD_RXTHR
  } rdsel_t;

endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strb,
  output rdsel_t            rdSel
);

  // Write decode: one strobe per writable address.
  always_comb begin
    strb = '0;
    if (busWe) begin
      case (busAddr)
        ADDR_W'(OFF_STAT):  strb.statClr = 1'b1;
        ADDR_W'(OFF_MSET):  strb.maskSet = 1'b1;
        ADDR_W'(OFF_MCLR):  strb.maskClr = 1'b1;
        ADDR_W'(OFF_TXTHR): strb.txThrWr = 1'b1;
        ADDR_W'(OFF_RXTHR): strb.rxThrWr = 1'b1;
        default: ;
      endcase
    end
  end

  // Read decode: set and clear addresses read as zero.
  always_comb begin
    case (busAddr)
      ADDR_W'(OFF_STAT):  rdSel = RD_STAT;
      ADDR_W'(OFF_MASK):  rdSel = RD_MASK;
      ADDR_W'(OFF_TXTHR): rdSel = RD_TXTHR;
      ADDR_W'(OFF_RXTHR): rdSel = RD_RXTHR;
      default:            rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_unit_pkg::*;
#(
  parameter int FIFO_DEPTH  = 63,
  parameter int LVL_W       = 6,
  parameter int WD_W        = 7,
  parameter int TX_THR_INIT = 1,
  parameter int RX_THR_INIT = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  rdsel_t           rdSel,
  input  logic [WD_W-1:0]  wd,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  output logic [31:0]      rdData,
  output logic [IRQ_W-1:0] statusQ,
  output logic [IRQ_W-1:0] maskQ,
  output logic [LVL_W-1:0] txThrQ,
  output logic [LVL_W-1:0] rxThrQ,
  output logic             irq
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic [IRQ_W-1:0] cond;
  logic [IRQ_W-1:0] clrVec;

  // Live conditions; reserved positions stay zero.
  always_comb begin
    cond              = '0;
    cond[B_RX_AT_THR] = (rxLevel >= rxThrQ);
    cond[B_TX_BELOW]  = (txLevel <  txThrQ);
    cond[B_TX_FULL]   = (txLevel == FULL_LVL);
    cond[B_RX_AVAIL]  = (rxLevel != '0);
    cond[B_RX_FULL]   = (rxLevel == FULL_LVL);
  end

  assign clrVec = strb.statClr ? wd[IRQ_W-1:0] : '0;

  // One sticky flop per status bit; a clear in the same cycle wins.
  for (genvar k = 0; k < IRQ_W; k++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        statusQ[k] <= 1'b0;
      else
        statusQ[k] <= (statusQ[k] | cond[k]) & ~clrVec[k];
    end
  end

  // Mask: set-only and clear-only ports.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      maskQ <= '0;
    else if (strb.maskSet)
      maskQ <= maskQ | wd[IRQ_W-1:0];
    else if (strb.maskClr)
      maskQ <= maskQ & ~wd[IRQ_W-1:0];
  end

  // Threshold registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThrQ <= LVL_W'(TX_THR_INIT);
      rxThrQ <= LVL_W'(RX_THR_INIT);
    end else begin
      if (strb.txThrWr) txThrQ <= wd[LVL_W-1:0];
      if (strb.rxThrWr) rxThrQ <= wd[LVL_W-1:0];
    end
  end

  assign irq = |(statusQ & maskQ);

  always_comb begin
    case (rdSel)
      RD_STAT:  rdData = 32'(statusQ);
      RD_MASK:  rdData = 32'(maskQ);
      RD_TXTHR: rdData = 32'(txThrQ);
      RD_RXTHR: rdData = 32'(rxThrQ);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FIFO_DEPTH  = 63,
  parameter int TX_THR_INIT = 1,
  parameter int RX_THR_INIT = 32,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  output logic              irq
);

  localparam int WD_W = (LVL_W > IRQ_W) ? LVL_W : IRQ_W;

  strobe_t          strb;
  rdsel_t           rdSel;
  logic [IRQ_W-1:0] statusQ;
  logic [IRQ_W-1:0] maskQ;
  logic [LVL_W-1:0] txThrQ;
  logic [LVL_W-1:0] rxThrQ;
  logic             unusedWdataHi;

  assign unusedWdataHi = ^busWdata[31:WD_W];

  irq_status_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  irq_status_dp #(
    .FIFO_DEPTH  (FIFO_DEPTH),
    .LVL_W       (LVL_W),
    .WD_W        (WD_W),
    .TX_THR_INIT (TX_THR_INIT),
    .RX_THR_INIT (RX_THR_INIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .wd      (busWdata[WD_W-1:0]),
    .txLevel (txLevel),
    .rxLevel (rxLevel),
    .rdData  (busRdata),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .txThrQ  (txThrQ),
    .rxThrQ  (rxThrQ),
    .irq     (irq)
  );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [IRQ_W-1:0]  wdLow,
  input logic [LVL_W-1:0]  txLevel,
  input logic [LVL_W-1:0]  rxLevel,
  input logic [LVL_W-1:0]  txThrQ,
  input logic [IRQ_W-1:0]  statusQ,
  input logic [IRQ_W-1:0]  maskQ,
  input logic              irq
);

  logic             wrStat, wrSet, wrClr;
  logic [IRQ_W-1:0] clrBits;

  assign wrStat  = busWe && (busAddr == ADDR_W'(OFF_STAT));
  assign wrSet   = busWe && (busAddr == ADDR_W'(OFF_MSET));
  assign wrClr   = busWe && (busAddr == ADDR_W'(OFF_MCLR));
  assign clrBits = wrStat ? wdLow : '0;

  // R2
  tx_below_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((txLevel < txThrQ) && !clrBits[B_TX_BELOW]) |=> statusQ[B_TX_BELOW]);

  // R3
  rx_avail_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rxLevel != '0) && !clrBits[B_RX_AVAIL]) |=> statusQ[B_RX_AVAIL]);

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusQ) & ~$past(clrBits)) & ~statusQ) == '0));

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStat |=> ((statusQ & $past(wdLow)) == '0));

  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> ((maskQ & $past(wdLow)) == $past(wdLow)));

  // R8
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> ((maskQ & $past(wdLow)) == '0));

  // R9
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);

endmodule

bind irq_status_unit irq_status_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWe   (busWe),
  .wdLow   (busWdata[irq_unit_pkg::IRQ_W-1:0]),
  .txLevel (txLevel),
  .rxLevel (rxLevel),
  .txThrQ  (txThrQ),
  .statusQ (statusQ),
  .maskQ   (maskQ),
  .irq     (irq)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;

  localparam int LW = 6;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [LW-1:0] txLevel = '0;
  logic [LW-1:0] rxLevel = '0;
  logic        irq;

  int nTests = 0;
  int nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata),
    .txLevel(txLevel), .rxLevel(rxLevel), .irq(irq)
  );

  // Row: {tx, rx, txThr, rxThr, mask, expected status}
  localparam logic [39:0] VEC [NV] = '{
    {6'd0,  6'd0,  6'd1,  6'd32, 8'h04, 8'h04},
    {6'd1,  6'd0,  6'd1,  6'd32, 8'h04, 8'h00},
    {6'd63, 6'd63, 6'd1,  6'd32, 8'h3A, 8'h3A},
    {6'd5,  6'd31, 6'd8,  6'd32, 8'h10, 8'h14},
    {6'd8,  6'd32, 6'd8,  6'd32, 8'h02, 8'h12},
    {6'd7,  6'd1,  6'd8,  6'd1,  8'h7F, 8'h16},
    {6'd0,  6'd0,  6'd0,  6'd0,  8'h01, 8'h02},
    {6'd62, 6'd62, 6'd63, 6'd63, 8'h20, 8'h14}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] v;
    // R1: values while reset is held
    #1;
    readReg(8'h04, v); check("R1 status", v, 32'h0);
    readReg(8'h10, v); check("R1 mask", v, 32'h0);
    readReg(8'h28, v); check("R1 txThr", v, 32'd1);
    readReg(8'h2C, v); check("R1 rxThr", v, 32'd32);
    check("R1 irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // Table walk: R2 R3 R4 conditions and R9 gating
    for (int i = 0; i < NV; i++) begin
      logic [7:0] mk, ex;
      txLevel = VEC[i][39:34];
      rxLevel = VEC[i][33:28];
      mk = VEC[i][15:8];
      ex = VEC[i][7:0];
      busWrite(8'h28, 32'(VEC[i][27:22]));
      busWrite(8'h2C, 32'(VEC[i][21:16]));
      busWrite(8'h0C, 32'h7F);
      busWrite(8'h08, 32'(mk));
      busWrite(8'h04, 32'h7F);
      tick();
      readReg(8'h04, v);
      check($sformatf("R2 R3 R4 row %0d status", i), v, 32'(ex));
      check($sformatf("R9 row %0d irq", i), {31'b0, irq}, {31'b0, |(ex & mk)});
    end

    // R5 and R6: sticky bits and selective clear
    txLevel = 6'd1; rxLevel = 6'd0;
    busWrite(8'h28, 32'd1);
    busWrite(8'h2C, 32'd32);
    busWrite(8'h04, 32'h7F);
    tick();
    readReg(8'h04, v); check("R6 clear all", v, 32'h0);
    rxLevel = 6'd63;
    tick();
    rxLevel = 6'd0;
    tick(); tick();
    readReg(8'h04, v); check("R5 sticky after pulse", v, 32'h32);
    busWrite(8'h04, 32'h20);
    readReg(8'h04, v); check("R6 zeros leave bits", v, 32'h12);
    tick();
    readReg(8'h04, v); check("R6 no reassert without cond", v, 32'h12);

    // R6: clear while condition persists
    txLevel = 6'd0;
    tick();
    readReg(8'h04, v); check("R2 tx below", v, 32'h16);
    busWrite(8'h04, 32'h04);
    readReg(8'h04, v); check("R6 cleared cycle", v, 32'h12);
    tick();
    readReg(8'h04, v); check("R6 reassert", v, 32'h16);

    // R7 R8 R9: mask set/clear and irq
    busWrite(8'h0C, 32'h7F);
    readReg(8'h10, v); check("R8 clear all", v, 32'h0);
    check("R9 masked off", {31'b0, irq}, 32'h0);
    busWrite(8'h08, 32'h14);
    readReg(8'h10, v); check("R7 set", v, 32'h14);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    busWrite(8'h08, 32'h01);
    readReg(8'h10, v); check("R7 accumulate", v, 32'h15);
    busWrite(8'h0C, 32'h04);
    readReg(8'h10, v); check("R8 clear one", v, 32'h11);
    check("R9 still on", {31'b0, irq}, 32'h1);
    busWrite(8'h0C, 32'h10);
    check("R9 off", {31'b0, irq}, 32'h0);
    busWrite(8'h0C, 32'h0);
    readReg(8'h10, v); check("R8 zero write", v, 32'h01);
    busWrite(8'h08, 32'h0);
    readReg(8'h10, v); check("R7 zero write", v, 32'h01);
    busWrite(8'h08, 32'hFFFF_FFFF);
    readReg(8'h10, v); check("R7 upper ignored", v, 32'h7F);

    // R4: reserved bits with every condition driven
    txLevel = 6'd63; rxLevel = 6'd63;
    busWrite(8'h04, 32'h7F);
    tick();
    readReg(8'h04, v);
    check("R4 full status", v, 32'h3A);
    check("R4 reserved zero", v & 32'hFFFF_FF81, 32'h0);

    // R10: threshold width
    busWrite(8'h28, 32'hFFFF_FF05);
    readReg(8'h28, v); check("R10 txThr", v, 32'h05);
    busWrite(8'h2C, 32'hABCD_EF2A);
    readReg(8'h2C, v); check("R10 rxThr", v, 32'h2A);

    // R11: write-only and unmapped addresses
    readReg(8'h08, v); check("R11 set addr", v, 32'h0);
    readReg(8'h0C, v); check("R11 clr addr", v, 32'h0);
    readReg(8'h30, v); check("R11 unmapped", v, 32'h0);

    done = 1;
    finishRun();
  end

endmodule